// File: doc/BRIEF.md
# Write-Buffered Wide Control Register

This block holds a control register that is wider than the host access width. The host writes it one access-width slice at a time. Each write lands in a shadow buffer. The live register, which drives the hardware, copies the whole buffer in one cycle only when a commit trigger occurs. Downstream logic therefore never sees a half-updated multi-slice value.

A parameter picks one of four commit trigger sources:

- 0: the register triggers itself. The commit uses a one-cycle delayed copy of the write to its top slice, so that slice's data is already buffered when the copy is taken.
- 1: a host write to the top slice of a separate trigger register.
- 2: an external level with selectable polarity.
- 3: the current level of a single control bit.

The block reports a pending flag while the buffer holds data that has not been committed.

Top module: `wbuf_reg`

## Requirements
- R1: The register is split into REG_W/ACC_W slices. Slice i is selected by wr_strb[i]. A write (wr_en high with a slice strobe set) replaces only the bits of that slice whose wr_biten bit is 1, and sets pending on the next cycle.
- R2: live loads the full buffer content, as it was before that cycle's write, exactly on clock edges where pending and the selected trigger are both high. On every other edge live holds its value.
- R3: After a commit edge, pending is 0, unless a write occurred on that same edge, in which case pending stays 1.
- R4: With TRIG_SEL=1, the trigger is wr_en together with the top bit of trig_strb (index TRIG_REG_W/ACC_W-1). Strobes to lower slices of the trigger register do not commit.
- R5: With TRIG_SEL=1 and TRIG_REG_W equal to ACC_W, any write to the trigger register (trig_strb[0]) commits.
- R6: With TRIG_SEL=2, ext_trig triggers when high if EXT_ACT_HIGH=1, and when low if EXT_ACT_HIGH=0.
- R7: With TRIG_SEL=3, the level of fld_trig at the clock edge is the trigger.
- R8: With TRIG_SEL=0, a write to the top slice commits on the following edge, never on the write edge itself. The committed value includes that top-slice write.
- R9: Reset (rst_n low, asynchronous) sets live, the buffer, pending and the delayed trigger to zero.
- R10: A trigger while pending is 0 leaves live and pending unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_strb | input | REG_W/ACC_W | Per-slice select of this register |
| wr_en | input | 1 | Host write enable |
| wr_data | input | ACC_W | Host write data |
| wr_biten | input | ACC_W | Per-bit write mask |
| trig_strb | input | TRIG_REG_W/ACC_W | Per-slice select of the trigger register |
| ext_trig | input | 1 | External trigger level |
| fld_trig | input | 1 | Trigger control bit |
| live | output | REG_W | Committed register value |
| pending | output | 1 | Buffer holds uncommitted data |

## Verification
The hardest case to reach from the ports is a commit that lands on the same edge as a new write. The live value must then take the old buffer content, and pending must survive. In self-trigger mode this needs two top-slice writes on consecutive cycles, or a lower-slice write right after a top-slice write.

Directed sequences build that case and the delayed self commit explicitly. A long random run drives five instances, one per trigger variant, from shared stimulus. Dense back-to-back writes mixed with sparse triggers produce many such overlaps, and a bench model checks every cycle.

// File: rtl/wbuf_reg.sv
module wbuf_reg #(
  parameter int REG_W        = 64,
  parameter int ACC_W        = 16,
  parameter int TRIG_SEL     = 0,
  parameter int TRIG_REG_W   = 32,
  parameter bit EXT_ACT_HIGH = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [REG_W/ACC_W-1:0]      wr_strb,
  input  logic                        wr_en,
  input  logic [ACC_W-1:0]            wr_data,
  input  logic [ACC_W-1:0]            wr_biten,
  input  logic [TRIG_REG_W/ACC_W-1:0] trig_strb,
  input  logic                        ext_trig,
  input  logic                        fld_trig,
  output logic [REG_W-1:0]            live,
  output logic                        pending
);
  localparam int NSUB = REG_W / ACC_W;
  localparam int TSUB = TRIG_REG_W / ACC_W;

  logic [NSUB-1:0][ACC_W-1:0] shd_q;
  logic trig_q;
  logic wr_any, self_raw, oth_raw, ext_lvl, trig, commit;
  logic [3:0] trig_opts;

  assign wr_any    = wr_en && (|wr_strb);
  assign self_raw  = wr_en && wr_strb[NSUB-1];
  assign oth_raw   = wr_en && trig_strb[TSUB-1];
  assign ext_lvl   = EXT_ACT_HIGH ? ext_trig : ~ext_trig;
  assign trig_opts = {fld_trig, ext_lvl, oth_raw, trig_q};
  assign trig      = trig_opts[TRIG_SEL[1:0]];
  assign commit    = pending && trig;

  for (genvar i = 0; i < NSUB; i++) begin : g_slice
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        shd_q[i] <= '0;
      else if (wr_en && wr_strb[i])
        shd_q[i] <= (shd_q[i] & ~wr_biten) | (wr_data & wr_biten);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= 1'b0;
      pending <= 1'b0;
      live    <= '0;
    end else begin
      trig_q <= self_raw;
      if (commit) live <= shd_q;
      if (wr_any) pending <= 1'b1;
      else if (commit) pending <= 1'b0;
    end
  end

  // R1
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> pending);

  // R3
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wr_any) |=> !pending);

  // R2
  commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (live == $past(shd_q)));

  // R2
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(live));

  // R10
  idle_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !wr_any) |=> (!pending && $stable(live)));

  if (TRIG_SEL == 0) begin : g_self_chk
    // R8
    self_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      self_raw |=> commit);
  end
endmodule

// File: tb/tb_wbuf_reg.sv
module tb_wbuf_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  wr_strb = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0, wr_biten = '0;
  logic [1:0]  oth_strb = '0;
  logic        one_strb = 1'b0, ext_n = 1'b1, fld = 1'b0;
  logic [63:0] lv [5];
  logic        pd [5];
  int nvec = 0, nbad = 0;

  always #2.5 clk = ~clk;

  wbuf_reg #(.TRIG_SEL(0)) dut (.clk, .rst_n, .wr_strb, .wr_en, .wr_data, .wr_biten,
    .trig_strb(oth_strb), .ext_trig(ext_n), .fld_trig(fld), .live(lv[0]), .pending(pd[0]));
  wbuf_reg #(.TRIG_SEL(1)) u_oth (.clk, .rst_n, .wr_strb, .wr_en, .wr_data, .wr_biten,
    .trig_strb(oth_strb), .ext_trig(ext_n), .fld_trig(fld), .live(lv[1]), .pending(pd[1]));
  wbuf_reg #(.TRIG_SEL(1), .TRIG_REG_W(16)) u_one (.clk, .rst_n, .wr_strb, .wr_en, .wr_data,
    .wr_biten, .trig_strb(one_strb), .ext_trig(ext_n), .fld_trig(fld), .live(lv[2]), .pending(pd[2]));
  wbuf_reg #(.TRIG_SEL(2), .EXT_ACT_HIGH(1'b0)) u_extl (.clk, .rst_n, .wr_strb, .wr_en, .wr_data,
    .wr_biten, .trig_strb(oth_strb), .ext_trig(ext_n), .fld_trig(fld), .live(lv[3]), .pending(pd[3]));
  wbuf_reg #(.TRIG_SEL(3)) u_fld (.clk, .rst_n, .wr_strb, .wr_en, .wr_data, .wr_biten,
    .trig_strb(oth_strb), .ext_trig(ext_n), .fld_trig(fld), .live(lv[4]), .pending(pd[4]));

  // reference model
  logic [3:0][15:0] m_shd;
  logic [63:0] m_live [5];
  logic        m_pend [5];
  logic        m_tq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_shd = '0; m_tq = 1'b0;
      for (int k = 0; k < 5; k++) begin m_live[k] = '0; m_pend[k] = 1'b0; end
    end else begin
      logic [4:0] t;
      logic wa;
      wa = wr_en && (|wr_strb);
      t[0] = m_tq;
      t[1] = wr_en && oth_strb[1];
      t[2] = wr_en && one_strb;
      t[3] = ~ext_n;
      t[4] = fld;
      for (int k = 0; k < 5; k++) begin
        if (m_pend[k] && t[k]) begin
          m_live[k] = m_shd;
          m_pend[k] = 1'b0;
        end
        if (wa) m_pend[k] = 1'b1;
      end
      m_tq = wr_en && wr_strb[3];
      for (int i = 0; i < 4; i++)
        if (wr_en && wr_strb[i]) m_shd[i] = (m_shd[i] & ~wr_biten) | (wr_data & wr_biten);
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      chk($sformatf("R2 live inst%0d", k), lv[k], m_live[k]);
      chk($sformatf("R3 pending inst%0d", k), {63'd0, pd[k]}, {63'd0, m_pend[k]});
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_strb = '0; oth_strb = '0; one_strb = 1'b0; ext_n = 1'b1; fld = 1'b0;
  endtask

  task automatic wr(int s, logic [15:0] d, logic [15:0] be);
    idle(); wr_en = 1'b1; wr_strb = 4'(1 << s); wr_data = d; wr_biten = be;
  endtask

  localparam logic [63:0] V1 = 64'h4444_3333_2222_1111;

  initial begin
    void'($urandom(32'd2024));
    #20.5;
    @(negedge clk);
    // R9 reset state
    chk("R9 live", lv[0], 64'd0);
    chk("R9 pending", {63'd0, pd[0]}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 write slices 0..2, nothing commits (R2)
    wr(0, 16'h1111, 16'hFFFF); cyc();
    wr(1, 16'h2222, 16'hFFFF); cyc();
    wr(2, 16'h3333, 16'hFFFF); cyc();
    chk("R1 pending set", {63'd0, pd[0]}, 64'd1);
    chk("R6 inactive high level ignored", lv[3], 64'd0);
    // R8 top slice write: no commit on this edge
    wr(3, 16'h4444, 16'hFFFF); cyc();
    chk("R8 not on write edge", lv[0], 64'd0);
    idle(); cyc();
    chk("R8 delayed commit", lv[0], V1);
    chk("R3 self pending clear", {63'd0, pd[0]}, 64'd0);
    // R4 lower trigger slice does nothing, top slice commits
    idle(); wr_en = 1'b1; oth_strb = 2'b01; cyc();
    chk("R4 low slice ignored", lv[1], 64'd0);
    idle(); wr_en = 1'b1; oth_strb = 2'b10; cyc();
    chk("R4 top slice commit", lv[1], V1);
    // R5 single-slice trigger register
    idle(); wr_en = 1'b1; one_strb = 1'b1; cyc();
    chk("R5 commit", lv[2], V1);
    // R6 active-low external
    idle(); ext_n = 1'b0; cyc();
    chk("R6 active low commit", lv[3], V1);
    // R7 field bit
    idle(); fld = 1'b1; cyc();
    chk("R7 field commit", lv[4], V1);
    // R10 trigger with nothing pending
    idle(); fld = 1'b1; cyc();
    chk("R10 live unchanged", lv[4], V1);
    chk("R10 pending stays 0", {63'd0, pd[4]}, 64'd0);
    // R1 masked merge into slice 1 only
    wr(1, 16'hFFFF, 16'h00F0); cyc();
    // R3 commit coincides with a write: old buffer, pending stays
    wr(2, 16'hABCD, 16'hFFFF); fld = 1'b1; cyc();
    chk("R3 commit takes pre-write buffer", lv[4], 64'h4444_3333_22F2_1111);
    chk("R3 pending kept", {63'd0, pd[4]}, 64'd1);
    // R8 back-to-back top writes
    wr(3, 16'h5555, 16'hFFFF); cyc();
    wr(3, 16'h6666, 16'hFFFF); cyc();
    chk("R8 first top commit", lv[0], 64'h5555_ABCD_22F2_1111);
    idle(); cyc();
    chk("R8 second top commit", lv[0], 64'h6666_ABCD_22F2_1111);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      idle();
      wr_en    = ($urandom % 4) != 0;
      wr_strb  = ($urandom % 5 == 0) ? 4'd0 : 4'(1 << ($urandom % 4));
      wr_data  = 16'($urandom);
      wr_biten = ($urandom % 2) ? 16'hFFFF : 16'($urandom);
      oth_strb = ($urandom % 6 == 0) ? 2'(1 << ($urandom % 2)) : 2'd0;
      one_strb = ($urandom % 7 == 0);
      ext_n    = ($urandom % 6) != 0;
      fld      = ($urandom % 6) == 0;
      cyc();
    end
    // R9 reset mid-operation
    idle(); rst_n = 1'b0; #1;
    chk("R9 async live", lv[0], 64'd0);
    chk("R9 async pending", {63'd0, pd[4]}, 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #400000;
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule